// File: doc/BRIEF.md
# Multi-Channel Frame Timing Generator

This block produces a set of timing waveforms for time-division duplex radio front ends and for general event sequencing. A reference counter walks through frames of programmable length; frames are grouped into bursts whose size is also programmable. Every output channel owns a window inside the frame, given by a start and a stop position. The channel asserts while the counter lies inside that window, and it does so in every frame of the burst.

Software, or a controller on chip, loads all settings through a flat write port. The settings are the frame length, the frames per burst, the delay from sync to the first frame, the period of the internal sync, the per-channel window positions, and the per-channel enable and polarity masks. Once the generator is enabled it sits armed. One of three sources can start a burst: an external pin, a periodic pulse generated inside the block, or a strobe written by software. A source selector picks which of these counts. After the delay, the frames run. When the burst completes the block returns to armed and waits for the next sync.

Top module: `tdd_wavegen`

## Requirements
- R1: After reset the generator is idle, every setting is zero and every channel output is low.
- R2: Writes land when `cfg_we` is high. Address 0 is control: bit 0 enables the generator, bits 2:1 select the sync source, and bit 3 is a one-shot software sync. The other global settings are at these addresses: 1 frame length, 2 frames per burst, 3 startup delay, 4 internal sync period, 5 channel enable mask, 6 polarity mask. Channel c takes its start at address 64+2c and its stop at address 65+2c.
- R3: When start is not above stop, a channel is active while start <= count < stop. A channel whose start equals its stop is never active.
- R4: When start is above stop, the window wraps across the frame edge: the channel is active while count >= start or count < stop.
- R5: A channel whose enable bit is clear always drives its inactive level.
- R6: Each output equals (active AND enabled) XOR the channel's polarity bit. Outside a running frame every output sits at its polarity bit.
- R7: Startup delay timing: let D be the startup delay and p the position counted from the start of the run. The output for position p appears on the D+2+p-th rising edge after the edge that accepts the sync.
- R8: The count runs from 0 to length-1 and then wraps to 0. A frame length of 0 behaves as a length of 1.
- R9: After B frames (B nonzero) the outputs return to their inactive levels and the block re-arms, so a later sync starts a new burst.
- R10: A burst count of 0 repeats frames until the enable bit is cleared. Two edges after the write that clears it, every output is back at its inactive level.
- R11: Source select codes are: 0 external pin, 1 internal periodic pulse, 2 software strobe, 3 none. A software strobe is accepted on the edge after its write.
- R12: The external pin passes through two synchronizing flops and a rising-edge detector. A rise sampled on edge X is accepted on edge X+2, and a level that stays high produces only one event.
- R13: With internal sync and a period P of at least 2, the first pulse is accepted P edges after the control write that selects it, and a pulse is accepted every P edges after that. P = 0 gives no pulses.
- R14: A sync that arrives while the generator is disabled, or during the delay or a running burst, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| ext_sync | input | 1 | Asynchronous external sync input |
| ch_out | output | NUM_CH | Registered channel waveforms |

## Verification
The bench sweeps every start/stop pair over a short frame, which covers empty windows, wrapped windows and windows that touch the frame edge. A design that mishandled the wrap would leave a channel dark, or lit for the whole frame, in the wrapped cases. Each output is compared on every cycle from the sync through to the end of the burst. A design that miscounted the delay or the pipeline registers would be off by one cycle. A design that miscounted the frames in a burst would stop early, or keep running after the last frame. Sync events are injected mid-burst, while the generator is disabled, and as a held-high external level. A design that restarted on any of these would shift the waveform or produce a burst where none belongs.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } tdd_state_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_INT  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_NONE = 2'd3
  } sync_src_e;

  localparam int A_CTRL    = 0;
  localparam int A_FLEN    = 1;
  localparam int A_BURST   = 2;
  localparam int A_DELAY   = 3;
  localparam int A_PERIOD  = 4;
  localparam int A_ENMASK  = 5;
  localparam int A_POLMASK = 6;
  localparam int A_CH_BASE = 64;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_SRC_LSB    = 1;
  localparam int CTRL_STROBE_BIT = 3;
endpackage

// File: rtl/tdd_cfg_regs.sv
module tdd_cfg_regs
  import tdd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output logic                            gen_en,
  output sync_src_e                       sync_src,
  output logic                            sw_strobe,
  output logic [CNT_W-1:0]                frame_len,
  output logic [CNT_W-1:0]                burst_len,
  output logic [CNT_W-1:0]                start_dly,
  output logic [CNT_W-1:0]                sync_period,
  output logic [NUM_CH-1:0]               ch_en,
  output logic [NUM_CH-1:0]               ch_pol,
  output logic [NUM_CH-1:0][CNT_W-1:0]    ch_start,
  output logic [NUM_CH-1:0][CNT_W-1:0]    ch_stop
);
  logic hit_ctrl;
  assign hit_ctrl = cfg_we && (cfg_addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en      <= 1'b0;
      sync_src    <= SRC_EXT;
      sw_strobe   <= 1'b0;
      frame_len   <= '0;
      burst_len   <= '0;
      start_dly   <= '0;
      sync_period <= '0;
      ch_en       <= '0;
      ch_pol      <= '0;
    end else begin
      sw_strobe <= hit_ctrl && cfg_wdata[CTRL_STROBE_BIT];
      if (hit_ctrl) begin
        gen_en   <= cfg_wdata[CTRL_EN_BIT];
        sync_src <= sync_src_e'(cfg_wdata[CTRL_SRC_LSB +: 2]);
      end
      if (cfg_we) begin
        if (cfg_addr == ADDR_W'(A_FLEN))    frame_len   <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == ADDR_W'(A_BURST))   burst_len   <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == ADDR_W'(A_DELAY))   start_dly   <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == ADDR_W'(A_PERIOD))  sync_period <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == ADDR_W'(A_ENMASK))  ch_en       <= cfg_wdata[NUM_CH-1:0];
        if (cfg_addr == ADDR_W'(A_POLMASK)) ch_pol      <= cfg_wdata[NUM_CH-1:0];
      end
    end
  end

  // One start/stop register pair per channel, at consecutive addresses
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chreg
    logic [CNT_W-1:0] start_q, stop_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        start_q <= '0;
        stop_q  <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(A_CH_BASE + 2*c))     start_q <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == ADDR_W'(A_CH_BASE + 2*c + 1)) stop_q  <= cfg_wdata[CNT_W-1:0];
      end
    end
    assign ch_start[c] = start_q;
    assign ch_stop[c]  = stop_q;
  end
endmodule

// File: rtl/tdd_sync_sel.sv
module tdd_sync_sel
  import tdd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  input  sync_src_e        sync_src,
  input  logic             sw_strobe,
  input  logic             ext_sync,
  input  logic [CNT_W-1:0] sync_period,
  output logic             sync_evt
);
  logic             meta_q, sync_q, prev_q;
  logic [CNT_W-1:0] tick_q;
  logic             ext_evt, int_evt, sw_evt, int_on;

  // Two-flop synchronizer followed by a rising-edge detector
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ext_sync;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign int_on = gen_en && (sync_src == SRC_INT) && (sync_period != '0);

  // Periodic internal pulse, restarted whenever it is not selected
  always_ff @(posedge clk) begin
    if (rst || !int_on) begin
      tick_q <= '0;
    end else if (tick_q == sync_period - CNT_W'(1)) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + CNT_W'(1);
    end
  end

  assign ext_evt  = (sync_src == SRC_EXT) && sync_q && !prev_q;
  assign int_evt  = int_on && (tick_q == sync_period - CNT_W'(1));
  assign sw_evt   = (sync_src == SRC_SW) && sw_strobe;
  assign sync_evt = ext_evt || int_evt || sw_evt;
endmodule

// File: rtl/tdd_frame_ctrl.sv
module tdd_frame_ctrl
  import tdd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  input  logic             sync_evt,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] start_dly,
  output tdd_state_e       state,
  output logic             running,
  output logic [CNT_W-1:0] ref_cnt
);
  logic [CNT_W-1:0] dly_q, frame_idx_q, last_pos;
  logic             at_frame_end, at_last_frame;

  assign last_pos      = (frame_len == '0) ? '0 : frame_len - CNT_W'(1);
  assign at_frame_end  = ref_cnt >= last_pos;
  assign at_last_frame = (burst_len != '0) && (frame_idx_q >= burst_len - CNT_W'(1));
  assign running       = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dly_q       <= '0;
      ref_cnt     <= '0;
      frame_idx_q <= '0;
    end else if (!gen_en) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: state <= ST_ARMED;
        ST_ARMED: begin
          if (sync_evt) begin
            state <= ST_DELAY;
            dly_q <= '0;
          end
        end
        ST_DELAY: begin
          if (dly_q >= start_dly) begin
            state       <= ST_RUN;
            ref_cnt     <= '0;
            frame_idx_q <= '0;
          end else begin
            dly_q <= dly_q + CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (at_frame_end) begin
            ref_cnt <= '0;
            if (at_last_frame) state <= ST_ARMED;
            else               frame_idx_q <= frame_idx_q + CNT_W'(1);
          end else begin
            ref_cnt <= ref_cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdd_chan_bank.sv
module tdd_chan_bank #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         running,
  input  logic [CNT_W-1:0]             ref_cnt,
  input  logic [NUM_CH-1:0]            ch_en,
  input  logic [NUM_CH-1:0]            ch_pol,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ch_start,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ch_stop,
  output logic [NUM_CH-1:0]            ch_out
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic in_win, out_q;
    always_comb begin
      if (ch_start[c] <= ch_stop[c])
        in_win = (ref_cnt >= ch_start[c]) && (ref_cnt < ch_stop[c]);
      else
        in_win = (ref_cnt >= ch_start[c]) || (ref_cnt < ch_stop[c]);
    end
    always_ff @(posedge clk) begin
      if (rst) out_q <= 1'b0;
      else     out_q <= (running && ch_en[c] && in_win) ^ ch_pol[c];
    end
    assign ch_out[c] = out_q;
  end
endmodule

// File: rtl/tdd_wavegen.sv
module tdd_wavegen
  import tdd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ext_sync,
  output logic [NUM_CH-1:0] ch_out
);
  logic                         gen_en, sw_strobe, sync_evt, running;
  sync_src_e                    sync_src;
  tdd_state_e                   state;
  logic [CNT_W-1:0]             frame_len, burst_len, start_dly, sync_period, ref_cnt;
  logic [NUM_CH-1:0]            ch_en, ch_pol;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_start, ch_stop;

  tdd_cfg_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .gen_en(gen_en), .sync_src(sync_src), .sw_strobe(sw_strobe),
    .frame_len(frame_len), .burst_len(burst_len), .start_dly(start_dly),
    .sync_period(sync_period), .ch_en(ch_en), .ch_pol(ch_pol),
    .ch_start(ch_start), .ch_stop(ch_stop)
  );

  tdd_sync_sel #(.CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst(rst), .gen_en(gen_en), .sync_src(sync_src), .sw_strobe(sw_strobe),
    .ext_sync(ext_sync), .sync_period(sync_period), .sync_evt(sync_evt)
  );

  tdd_frame_ctrl #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst), .gen_en(gen_en), .sync_evt(sync_evt),
    .frame_len(frame_len), .burst_len(burst_len), .start_dly(start_dly),
    .state(state), .running(running), .ref_cnt(ref_cnt)
  );

  tdd_chan_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .running(running), .ref_cnt(ref_cnt),
    .ch_en(ch_en), .ch_pol(ch_pol), .ch_start(ch_start), .ch_stop(ch_stop),
    .ch_out(ch_out)
  );
endmodule

// File: rtl/tdd_wavegen_checker.sv
module tdd_wavegen_checker
  import tdd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              gen_en,
  input logic              sync_evt,
  input tdd_state_e        state,
  input logic [CNT_W-1:0]  ref_cnt,
  input logic [CNT_W-1:0]  frame_len,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_pol,
  input logic [NUM_CH-1:0] ch_out
);
  // R6: outside a running frame every output sits at its polarity bit
  a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
    ($past(state) != ST_RUN) |-> (ch_out == $past(ch_pol)));

  // R5: a disabled channel never leaves its inactive level
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    ((ch_out ^ $past(ch_pol)) & ~$past(ch_en)) == '0);

  // R8: the counter stays inside the frame
  a_r8_cnt_in_frame: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> ((ref_cnt < frame_len) || (ref_cnt == '0)));

  // R8: inside a frame the counter advances by one per cycle
  a_r8_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && gen_en && frame_len != '0 && ref_cnt < frame_len - CNT_W'(1))
      |=> (state == ST_RUN && ref_cnt == $past(ref_cnt) + CNT_W'(1)));

  // R7: an armed generator that sees a sync enters the delay phase
  a_r7_sync_starts_delay: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && gen_en && sync_evt) |=> (state == ST_DELAY));

  // R14: a sync during a running burst does not restart it
  a_r14_sync_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && sync_evt) |=> (state != ST_DELAY));

  // R10: clearing the enable always returns the generator to idle
  a_r10_disable_idle: assert property (@(posedge clk) disable iff (rst)
    (!gen_en) |=> (state == ST_IDLE));
endmodule

bind tdd_wavegen tdd_wavegen_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .gen_en(gen_en), .sync_evt(sync_evt), .state(state),
  .ref_cnt(ref_cnt), .frame_len(frame_len), .ch_en(ch_en), .ch_pol(ch_pol),
  .ch_out(ch_out)
);

// File: tb/tdd_wavegen_test.sv
module tdd_wavegen_test;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          ext_sync = 1'b0;
  logic [NC-1:0] ch_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  int st_m [NC];
  int sp_m [NC];
  logic [NC-1:0] en_m = '0;
  logic [NC-1:0] pol_m = '0;

  always #10 clk = ~clk;

  tdd_wavegen #(.NUM_CH(NC), .CNT_W(8), .DATA_W(32), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_sync(ext_sync), .ch_out(ch_out)
  );

  // Expected outputs at run position p (negative: before the run)
  function automatic logic [NC-1:0] model(int p, int l, int b);
    logic [NC-1:0] r;
    int le = (l == 0) ? 1 : l;
    int pos;
    bit act;
    if (p < 0 || (b != 0 && p >= b * le)) return pol_m;
    pos = p % le;
    for (int c = 0; c < NC; c++) begin
      if (st_m[c] <= sp_m[c]) act = (pos >= st_m[c]) && (pos < sp_m[c]);
      else                    act = (pos >= st_m[c]) || (pos < sp_m[c]);
      r[c] = (en_m[c] && act) ^ pol_m[c];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NC-1:0] got, input logic [NC-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: ch_out=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = a[7:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ch(input int c, input int s, input int e);
    wr(64 + 2*c, s); wr(65 + 2*c, e);
    st_m[c] = s; sp_m[c] = e;
  endtask

  task automatic set_masks(input logic [NC-1:0] en, input logic [NC-1:0] pol);
    wr(5, int'(en)); wr(6, int'(pol));
    en_m = en; pol_m = pol;
  endtask

  // Software sync (enable, source 2, strobe); returns after the accepting edge
  task automatic sw_sync();
    wr(0, 1 | (2 << 1) | 8);
    @(negedge clk);
  endtask

  task automatic run_check(input int kmax, input int d, input int l, input int b, input string tag);
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      chk(tag, ch_out, model(k - d - 2, l, b));
    end
  endtask

  task automatic main_channels();
    set_ch(0, 2, 5);   // plain window
    set_ch(1, 7, 3);   // wrapping window
    set_ch(2, 4, 4);   // empty window
    set_ch(3, 0, 9);   // disabled below
    set_masks(4'b0111, 4'b0010);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin st_m[c] = 0; sp_m[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", ch_out, '0);

    // R2 R6: polarity mask alone sets the idle level
    wr(6, 4'b1010); pol_m = 4'b1010;
    @(negedge clk);
    chk("R6 R2 idle polarity", ch_out, 4'b1010);

    // R7 R3 R4 R5 R6 R9 R14: two-frame burst, delay 3, strobe mid-burst
    main_channels();
    wr(1, 10); wr(2, 2); wr(3, 3);
    wr(0, 1 | (2 << 1));
    sw_sync();
    for (int k = 1; k <= 29; k++) begin
      @(negedge clk);
      chk("R7 R14 burst timing", ch_out, model(k - 5, 10, 2));
      if (k == 8) begin cfg_we = 1'b1; cfg_addr = 8'd0; cfg_wdata = 32'd13; end
      if (k == 9) cfg_we = 1'b0;
    end
    // R9: re-armed after the burst
    sw_sync();
    run_check(29, 3, 10, 2, "R9 second burst");

    // R3 R4: every start/stop pair over a frame of 5
    wr(1, 5); wr(2, 1); wr(3, 0);
    for (int c = 1; c < NC; c++) set_ch(c, 0, 0);
    set_masks(4'b0001, 4'b0000);
    for (int s = 0; s <= 5; s++) begin
      for (int e = 0; e <= 5; e++) begin
        set_ch(0, s, e);
        sw_sync();
        run_check(8, 0, 5, 1, (s <= e) ? "R3 window" : "R4 wrapped window");
      end
    end

    // R11 R12: external source, level held high gives one burst
    main_channels();
    wr(1, 6); wr(2, 1); wr(3, 1);
    wr(0, 1);
    ext_sync = 1'b1;
    repeat (3) @(negedge clk);
    run_check(17, 1, 6, 1, "R12 R11 external sync");
    ext_sync = 1'b0;

    // R13: internal periodic sync, period 20
    wr(4, 20); wr(1, 4); wr(2, 2); wr(3, 2);
    wr(0, 1 | (1 << 1));
    repeat (20) @(negedge clk);
    run_check(15, 2, 4, 2, "R13 first internal pulse");
    repeat (5) @(negedge clk);
    run_check(15, 2, 4, 2, "R13 second internal pulse");

    // R10: burst count 0 runs until disabled
    wr(1, 4); wr(2, 0); wr(3, 0);
    wr(0, 1 | (2 << 1));
    sw_sync();
    run_check(30, 0, 4, 0, "R10 endless frames");
    wr(0, 0);
    repeat (2) @(negedge clk);
    chk("R10 disable to inactive", ch_out, pol_m);

    // R14: strobe while disabled has no effect, nor after enabling
    wr(0, (2 << 1) | 8);
    for (int k = 0; k < 6; k++) begin @(negedge clk); chk("R14 disabled strobe", ch_out, pol_m); end
    wr(0, 1 | (2 << 1));
    for (int k = 0; k < 6; k++) begin @(negedge clk); chk("R14 no late start", ch_out, pol_m); end

    // R8: frame length 0 acts as length 1
    wr(1, 0); wr(2, 3); wr(3, 0);
    set_ch(0, 0, 1);
    set_masks(4'b0001, 4'b0000);
    sw_sync();
    run_check(8, 0, 0, 3, "R8 zero frame length");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule